// File: doc/BRIEF.md
# Double-Buffered Dual-Channel DAC Serial Frontend

This block is the digital receive side of a two-channel 12-bit digital-to-analog converter. A host writes to it over a three-wire serial link made of an active-low select, a serial clock and one data line. Each transfer carries a 16-bit command word. The top four bits steer the transfer and set the operating flags. The low twelve bits are a converter code. When a word is committed, the block loads it into one or more of three 12-bit registers: the channel A code, the channel B code and a staging register. It also updates a speed flag and a power-down flag. The analog side reads the two codes and the two flags.

The staging register lets both channels change on the same commit. The host first writes the staging register only, then writes channel A. That write also copies the staged value into channel B. All logic runs on one system clock. The select and serial clock are synchronized and edge-detected inside the block, so the system clock must run at least four times the serial clock rate.

The parameter `FRAME_COUNT` gives a second mode that suits a frame-sync pulse driving the select line. In this mode a frame ends by itself after 16 serial clocks. A short word, where select rises before 16 clocks, is dropped by default. The parameter `COMMIT_PARTIAL` lets the block commit such a word when frame counting is off.

Top module: `dual_dac_serial_rx`

## Requirements
- R1: While select is low, one bit is taken from the data line on each falling serial clock edge, most significant bit first, into a 16-bit word. Bits [11:0] of the word are the code. Bits [15:12] are program bits.
- R2: Serial clock edges while select is high change no output and no stored value.
- R3: With frame counting off, a word is committed only on the rising edge of select. No output changes while select stays low.
- R4: A committed word with bit 15 = 1 loads the code into channel A and copies the staging register into channel B. The staging register keeps its value.
- R5: A committed word with bit 15 = 0 and bit 12 = 0 loads the code into both channel B and the staging register. Channel A keeps its value.
- R6: A committed word with bit 15 = 0 and bit 12 = 1 loads the code into the staging register only. Channels A and B keep their values.
- R7: Every committed word sets `fast_mode` from bit 14 (1 = fast) and `power_down` from bit 13 (1 = powered down).
- R8: Reset clears both channel codes and the staging register, and sets `fast_mode` = 0 and `power_down` = 0.
- R9: With frame counting on, the word is committed after the 16th falling edge without waiting for select to rise. Later serial clock edges are ignored until the next falling edge of select.
- R10: A frame in which select rises after fewer than 16 falling edges is dropped with no change. This holds in frame-counting mode, and with frame counting off when `COMMIT_PARTIAL` = 0.
- R11: With frame counting off and `COMMIT_PARTIAL` = 1, a short frame of N ≥ 1 bits is committed as a word whose low N bits are the received bits and whose upper bits are zero.
- R12: With frame counting off, more than 16 falling edges in one frame leave the last 16 bits received as the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |
| fast_mode | output | 1 | Speed flag: 1 = fast settling, 0 = slow |
| power_down | output | 1 | 1 = converter powered down |

## Verification
The assertions assume that `cs_n`, `sclk` and `sdin` each stay steady for at least two system clocks around every edge. They also assume that the data line is already settled when the serial clock falls, and that select never changes in the same system cycle as a serial clock edge. The stimulus holds each level of the serial clock for four system cycles and changes data and select only while the serial clock is high. It also leaves four idle cycles between select edges and the nearest serial clock edge. With those margins the synchronizers deliver edges that are clean and in order, and the routing and frame-length properties check real behaviour rather than sampling artefacts.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

    localparam int DAC_W   = 12;
    localparam int PROG_W  = 4;
    localparam int WORD_W  = DAC_W + PROG_W;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // Program-bit positions; the latch bank decodes these
    localparam int POS_SEL_A = WORD_W - 1;
    localparam int POS_FAST  = WORD_W - 2;
    localparam int POS_PDN   = WORD_W - 3;
    localparam int POS_STAGE = WORD_W - 4;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_A_SWAP,
        ROUTE_B_STAGE,
        ROUTE_STAGE
    } route_t;

    typedef struct packed {
        logic [DAC_W-1:0] a;
        logic [DAC_W-1:0] b;
        logic [DAC_W-1:0] stage;
        logic             fast;
        logic             pdn;
    } latch_state_t;

    typedef struct packed {
        logic              act;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sr;
        logic              commit;
    } rx_state_t;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [STAGES:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign prev_o  = pipe_q[STAGES];

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_rx_pkg::*;
#(
    parameter bit FRAME_COUNT    = 1'b0,
    parameter bit COMMIT_PARTIAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              cs_n_prev,
    input  logic              sclk_s,
    input  logic              sclk_prev,
    input  logic              din_s,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);

    localparam bit               PARTIAL_OK = COMMIT_PARTIAL && !FRAME_COUNT;
    localparam logic [CNT_W-1:0] FULL_CNT   = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(WORD_W - 1);

    rx_state_t rx_d, rx_q;
    logic      cs_fall, cs_rise, sclk_fall;

    assign cs_fall   = cs_n_prev & ~cs_n_s;
    assign cs_rise   = ~cs_n_prev & cs_n_s;
    assign sclk_fall = sclk_prev & ~sclk_s;

    always_comb begin
        rx_d        = rx_q;
        rx_d.commit = 1'b0;
        if (cs_fall) begin
            rx_d.act = 1'b1;
            rx_d.cnt = '0;
            rx_d.sr  = '0;
        end else if (rx_q.act) begin
            if (cs_rise) begin
                rx_d.act    = 1'b0;
                rx_d.commit = (rx_q.cnt == FULL_CNT) ||
                              (PARTIAL_OK && (rx_q.cnt != '0));
            end else if (sclk_fall) begin
                rx_d.sr = {rx_q.sr[WORD_W-2:0], din_s};
                if (rx_q.cnt != FULL_CNT) begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
                if (FRAME_COUNT && (rx_q.cnt == LAST_CNT)) begin
                    rx_d.act    = 1'b0;
                    rx_d.commit = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign commit_o = rx_q.commit;
    assign word_o   = rx_q.sr;

    AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_q.act && !cs_fall) |=> $stable(rx_q.sr)); // R2

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.commit |=> !rx_q.commit); // R3

    generate
        if (!PARTIAL_OK) begin : g_full_only
            AST_FULL_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                rx_q.commit |-> (rx_q.cnt == FULL_CNT)); // R10
        end
        if (FRAME_COUNT) begin : g_count
            AST_FRAME_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
                rx_q.commit |-> !rx_q.act); // R9
        end
    endgenerate

endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
    import dac_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [DAC_W-1:0]  code_a_o,
    output logic [DAC_W-1:0]  code_b_o,
    output logic              fast_o,
    output logic              pdn_o
);

    latch_state_t     st_d, st_q;
    route_t           route;
    logic [DAC_W-1:0] data;

    assign data = word_i[DAC_W-1:0];

    always_comb begin
        if (!commit_i) begin
            route = ROUTE_NONE;
        end else if (word_i[POS_SEL_A]) begin
            route = ROUTE_A_SWAP;
        end else if (word_i[POS_STAGE]) begin
            route = ROUTE_STAGE;
        end else begin
            route = ROUTE_B_STAGE;
        end
    end

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.fast = word_i[POS_FAST];
            st_d.pdn  = word_i[POS_PDN];
        end
        unique case (route)
            ROUTE_A_SWAP: begin
                st_d.a = data;
                st_d.b = st_q.stage;
            end
            ROUTE_B_STAGE: begin
                st_d.b     = data;
                st_d.stage = data;
            end
            ROUTE_STAGE: st_d.stage = data;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_a_o = st_q.a;
    assign code_b_o = st_q.b;
    assign fast_o   = st_q.fast;
    assign pdn_o    = st_q.pdn;

    AST_A_WRITE_COPIES_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && word_i[POS_SEL_A]) |=> (code_b_o == $past(st_q.stage))); // R4

    AST_A_WRITE_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && word_i[POS_SEL_A]) |=> $stable(st_q.stage)); // R4

    AST_B_SIDE_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !word_i[POS_SEL_A]) |=> $stable(code_a_o)); // R5

    AST_STAGE_ONLY_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !word_i[POS_SEL_A] && word_i[POS_STAGE]) |=> $stable(code_b_o)); // R6

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(st_q.a) && $stable(st_q.b) && $stable(st_q.stage)
                       && $stable(fast_o) && $stable(pdn_o))); // R3

    AST_FLAGS_FOLLOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (fast_o == $past(word_i[POS_FAST]) && pdn_o == $past(word_i[POS_PDN]))); // R7

endmodule

// File: rtl/dual_dac_serial_rx.sv
module dual_dac_serial_rx
    import dac_rx_pkg::*;
#(
    parameter bit FRAME_COUNT    = 1'b0,
    parameter bit COMMIT_PARTIAL = 1'b0,
    parameter int SYNC_STAGES    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdin,
    output logic [DAC_W-1:0] code_a,
    output logic [DAC_W-1:0] code_b,
    output logic             fast_mode,
    output logic             power_down
);

    // Bit order of the synchronized bundle: {select, serial clock, data}
    localparam int IN_W = 3;

    logic [IN_W-1:0]   pin_lvl, pin_prev;
    logic              commit;
    logic [WORD_W-1:0] word;

    dac_in_sync #(
        .WIDTH   (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({cs_n, sclk, sdin}),
        .level_o (pin_lvl),
        .prev_o  (pin_prev)
    );

    dac_frame_rx #(
        .FRAME_COUNT    (FRAME_COUNT),
        .COMMIT_PARTIAL (COMMIT_PARTIAL)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pin_lvl[2]),
        .cs_n_prev (pin_prev[2]),
        .sclk_s    (pin_lvl[1]),
        .sclk_prev (pin_prev[1]),
        .din_s     (pin_lvl[0]),
        .commit_o  (commit),
        .word_o    (word)
    );

    dac_latch_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .code_a_o (code_a),
        .code_b_o (code_b),
        .fast_o   (fast_mode),
        .pdn_o    (power_down)
    );

endmodule

// File: tb/test_dual_dac_serial_rx.sv
`timescale 1ns/1ps
module test_dual_dac_serial_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;

    always #2.5 clk = ~clk;

    // Three builds on one shared bus: plain, frame counting, partial commit
    logic [11:0] a0, b0, a1, b1, a2, b2;
    logic        f0, p0, f1, p1, f2, p2;

    dual_dac_serial_rx i_dual_dac_serial_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .code_a(a0), .code_b(b0), .fast_mode(f0), .power_down(p0));

    dual_dac_serial_rx #(.FRAME_COUNT(1'b1)) i_dual_dac_serial_rx_cnt (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .code_a(a1), .code_b(b1), .fast_mode(f1), .power_down(p1));

    dual_dac_serial_rx #(.COMMIT_PARTIAL(1'b1)) i_dual_dac_serial_rx_part (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .code_a(a2), .code_b(b2), .fast_mode(f2), .power_down(p2));

    // Stimulus word, expected channel A, channel B, {fast, power_down}
    localparam logic [15:0] VW [8] = '{16'h8FFF, 16'h4ABC, 16'h5123, 16'hC800,
                                       16'h2456, 16'h3777, 16'h0001, 16'h9000};
    localparam logic [11:0] VA [8] = '{12'hFFF, 12'hFFF, 12'hFFF, 12'h800,
                                       12'h800, 12'h800, 12'h800, 12'h000};
    localparam logic [11:0] VB [8] = '{12'h000, 12'hABC, 12'hABC, 12'h123,
                                       12'h456, 12'h456, 12'h001, 12'h001};
    localparam logic [1:0]  VM [8] = '{2'b00, 2'b10, 2'b10, 2'b10,
                                       2'b01, 2'b01, 2'b00, 2'b00};

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = v[i];
            tick(4);
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
        end
    endtask

    task automatic end_frame();
        tick(4);
        cs_n = 1'b1;
        tick(10);
    endtask

    function automatic string route_tag(input logic [15:0] w);
        if (w[15])      return "R1 R4";
        else if (w[12]) return "R1 R6";
        else            return "R1 R5";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(5);
        // R8: reset state
        check("R8 code_a", {4'h0, a0}, 16'h0);
        check("R8 code_b", {4'h0, b0}, 16'h0);
        check("R8 flags", {14'h0, f0, p0}, 16'h0);
        rst_n = 1'b1;
        tick(5);

        // Table of full frames, all three builds must agree
        for (int k = 0; k < 8; k++) begin
            send({16'h0, VW[k]}, 16);
            end_frame();
            check(route_tag(VW[k]), {4'h0, a0}, {4'h0, VA[k]});
            check(route_tag(VW[k]), {4'h0, b0}, {4'h0, VB[k]});
            check("R7 flags", {14'h0, f0, p0}, {14'h0, VM[k]});
            check("R9 count build a", {4'h0, a1}, {4'h0, VA[k]});
            check("R9 count build b", {4'h0, b1}, {4'h0, VB[k]});
            check("R11 partial build b", {4'h0, b2}, {4'h0, VB[k]});
        end

        // R3 / R9: 16 bits with select held low
        send(32'h8ABC, 16);
        tick(12);
        check("R3 no commit before select rise", {4'h0, a0}, 16'h000);
        check("R9 count build commits early a", {4'h0, a1}, 16'hABC);
        check("R9 count build b from stage", {4'h0, b1}, 16'h001);
        end_frame();
        check("R3 commit on select rise", {4'h0, a0}, 16'hABC);
        check("R3 partial build commit", {4'h0, a2}, 16'hABC);
        check("R9 count build no second commit", {4'h0, a1}, 16'hABC);

        // R2: clocks while deselected
        sdin = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick(4); sclk = 1'b0; tick(4); sclk = 1'b1;
        end
        tick(10);
        check("R2 deselected a", {4'h0, a0}, 16'hABC);
        check("R2 deselected b", {4'h0, b0}, 16'h001);
        check("R2 deselected flags", {14'h0, f0, p0}, 16'h0);

        // R10 / R11: short frame of 8 bits 0xAB
        send(32'hAB, 8);
        end_frame();
        check("R10 short frame dropped a", {4'h0, a0}, 16'hABC);
        check("R10 short frame dropped b", {4'h0, b0}, 16'h001);
        check("R10 count build short frame", {4'h0, b1}, 16'h001);
        check("R11 partial word right aligned", {4'h0, b2}, 16'h0AB);
        check("R11 partial keeps a", {4'h0, a2}, 16'hABC);

        // R12 / R9: 20 bits 0x80555
        send(32'h80555, 20);
        end_frame();
        check("R12 last sixteen bits b", {4'h0, b0}, 16'h555);
        check("R12 last sixteen bits a", {4'h0, a0}, 16'hABC);
        check("R12 partial build b", {4'h0, b2}, 16'h555);
        check("R9 count build first sixteen a", {4'h0, a1}, 16'h055);
        check("R9 count build extra clocks ignored b", {4'h0, b1}, 16'h001);

        // R8: reset again after activity
        rst_n = 1'b0;
        tick(3);
        check("R8 reset clears a", {4'h0, a1}, 16'h0);
        check("R8 reset clears b", {4'h0, b2}, 16'h0);
        check("R8 reset flags", {12'h0, f1, p1, f2, p2}, 16'h0);
        rst_n = 1'b1;
        tick(5);
        // R8: staging cleared too; an A write copies zero into B
        send(32'hC321, 16);
        end_frame();
        check("R8 stage cleared by reset", {4'h0, b0}, 16'h000);
        check("R4 a after reset", {4'h0, a0}, 16'h321);
        check("R7 fast flag", {15'h0, f0}, 16'h1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule